// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps time of day and date as packed BCD values. Each field holds two 4-bit digits, tens in the upper nibble and ones in the lower nibble. The fields are seconds, minutes, hours, weekday, day of month, month and two-digit year. A sub-second divider counts pulses of a 32.768 kHz clock enable and issues one advance per second. The advance ripples through the fields as each one wraps. Month lengths and leap-year February are handled without outside help.

A host sets the calendar through a single-cycle load strobe. The strobe supplies every field except seconds. Loading also zeroes the seconds and restarts the divider, so the next advance comes a whole second after the load. A hold input freezes the calendar and keeps the divider cleared, so that a host can change the fields without racing the advance. All fields are always visible in parallel on the snapshot outputs.

Top module: `bcd_calendar_counter`

## Requirements
- R1: Each field is 8-bit packed BCD, with the tens digit in bits 7:4 and the ones digit in bits 3:0. After a synchronous reset, the fields read seconds 00, minutes 00, hours 00, weekday 01, day 01, month 01 and year 00.
- R2: While hold and load are low, seconds advance by one at the clock edge that samples the 2^DIV_BITS-th asserted osc_en since the divider was last cleared. No clock edge that samples osc_en low changes any field.
- R3: Seconds wrap from 59 to 00 and advance minutes. Minutes wrap from 59 to 00 and advance hours. Hours wrap from 23 to 00 and advance both day and weekday.
- R4: Weekday counts 01 to 07 and wraps from 07 to 01.
- R5: Day wraps to 01 and advances the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and after day 28 in February of a non-leap year.
- R6: In a year whose two-digit value is divisible by 4 (year 00 included), February ends after day 29. Month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R7: While hold is high, no field changes and the divider stays cleared. After hold is released, the first advance comes on the edge that samples the 2^DIV_BITS-th enable.
- R8: A load strobe sampled at a clock edge writes minute, hour, weekday, day, month and year from the load inputs, sets seconds to 00 and clears the divider. The strobe takes effect whether or not hold is high.
- R9: Bits that a field never uses always read 0. Loaded values are masked to minute bits 6:0, hour bits 5:0, weekday bits 2:0, day bits 5:0 and month bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse at the 32.768 kHz oscillator rate |
| hold | input | 1 | Freezes the calendar and holds the divider cleared |
| load | input | 1 | Writes the load fields, clears seconds and divider |
| ld_min | input | 8 | BCD minute to load |
| ld_hour | input | 8 | BCD hour to load |
| ld_wday | input | 8 | BCD weekday to load |
| ld_day | input | 8 | BCD day of month to load |
| ld_month | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| tm_sec | output | 8 | Current seconds |
| tm_min | output | 8 | Current minutes |
| tm_hour | output | 8 | Current hours |
| tm_wday | output | 8 | Current weekday |
| tm_day | output | 8 | Current day of month |
| tm_month | output | 8 | Current month |
| tm_year | output | 8 | Current year |

## Verification
Every result of this block is due exactly one clock edge after its cause. A load shows up on the edge that samples the strobe, and a hold freezes the fields from the first edge that samples it. Each advance, including all the carries it causes, lands in the same edge that samples the last enable of a second. The bench drives inputs on falling edges. Its behavioural model steps on the same rising edge as the design, and the two are compared on the following falling edge. Directed checks count enables edge by edge to confirm that an advance is neither one enable early nor one enable late after a load or a hold release.

// File: rtl/rtc_pkg.sv
// Package: shared constants and helpers for the BCD calendar counter.
// Assumes every field is two packed BCD digits in one byte.
package rtc_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;

    // Field index map; the carry chain order follows these indices
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_WDAY  = 3;
    localparam int F_DAY   = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;

    // Per-field constants, element [NUM_FIELDS-1] first (year ... sec)
    localparam logic [NUM_FIELDS-1:0][FIELD_W-1:0] FIELD_MASK =
        {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F};
    localparam logic [NUM_FIELDS-1:0][FIELD_W-1:0] FIELD_LIMIT =
        {8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59};
    localparam logic [NUM_FIELDS-1:0][FIELD_W-1:0] FIELD_FIRST =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // Two-digit BCD increment; the caller handles wrap at the field limit
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        logic [FIELD_W-1:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_divider.sv
// Module: sub-second divider.
// Counts osc_en pulses and flags the last pulse of each second.
// Assumes osc_en is a single-cycle pulse at the oscillator rate.
// Clear (hold or load) zeroes the count and masks the tick.
module rtc_tick_divider #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic clear,
    output logic tick
);

    localparam logic [DIV_BITS-1:0] LAST = '1;

    logic [DIV_BITS-1:0] cnt;

    // Tick on the enable that completes a full period
    always_comb begin
        tick = osc_en && !clear && (cnt == LAST);
    end

    // Count enables; the counter wraps to zero on the tick itself
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (osc_en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_month_limit.sv
// Module: last day of the current month, in BCD.
// Leap test: a two-digit BCD year is divisible by 4 when its ones digit
// is even and bit 1 of that digit equals the tens-digit parity.
// Assumes the month holds a legal BCD value 01..12.
module rtc_month_limit (
    input  logic [7:0] month,
    input  logic       year_tens_lsb,
    input  logic [1:0] year_ones_lo,
    output logic [7:0] last_day
);

    logic leap;

    // Leap flag from the year digits without binary conversion
    always_comb begin
        leap = !year_ones_lo[0] && (year_ones_lo[1] == year_tens_lsb);
    end

    // Month length lookup
    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_field.sv
// Module: one two-digit BCD calendar field.
// Load has priority. An increment at the limit returns to WRAP_VAL and
// raises carry in the same cycle so that the next field advances together.
// Assumes limit and load values are legal BCD for the field.
module rtc_bcd_field #(
    parameter logic [7:0] MASK     = 8'hFF,
    parameter logic [7:0] RST_VAL  = 8'h00,
    parameter logic [7:0] WRAP_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic [7:0] limit,
    output logic [7:0] value,
    output logic       carry
);

    import rtc_pkg::*;

    // Carry out when an increment meets the field limit
    always_comb begin
        carry = inc && (value == limit);
    end

    // Field register: reset, load, wrap or BCD increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RST_VAL;
        end else if (load) begin
            value <= load_val & MASK;
        end else if (carry) begin
            value <= WRAP_VAL;
        end else if (inc) begin
            value <= bcd_inc(value) & MASK;
        end
    end

endmodule

// File: rtl/bcd_calendar_counter.sv
// Module: BCD calendar counter top.
// A divider turns osc_en pulses into a once-per-second tick. The tick
// ripples through seven BCD fields in one combinational carry chain.
// Hold freezes the calendar and clears the divider. Load writes every
// field except seconds, zeroes seconds and restarts the divider.
// Assumes load data are legal BCD; unused bits are masked on entry.
module bcd_calendar_counter #(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       hold,
    input  logic       load,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_day,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    output logic [7:0] tm_sec,
    output logic [7:0] tm_min,
    output logic [7:0] tm_hour,
    output logic [7:0] tm_wday,
    output logic [7:0] tm_day,
    output logic [7:0] tm_month,
    output logic [7:0] tm_year
);

    import rtc_pkg::*;

    logic               tick;
    logic               div_clear;
    logic [FIELD_W-1:0] day_last;
    logic               inc   [NUM_FIELDS];
    logic               carry [NUM_FIELDS];
    logic [FIELD_W-1:0] val   [NUM_FIELDS];
    logic [FIELD_W-1:0] lim   [NUM_FIELDS];
    logic [FIELD_W-1:0] ldv   [NUM_FIELDS];

    // Divider clear whenever the calendar is frozen or rewritten
    always_comb begin
        div_clear = hold || load;
    end

    rtc_tick_divider #(
        .DIV_BITS (DIV_BITS)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .clear  (div_clear),
        .tick   (tick)
    );

    rtc_month_limit u_mlim (
        .month         (val[F_MONTH]),
        .year_tens_lsb (val[F_YEAR][4]),
        .year_ones_lo  (val[F_YEAR][1:0]),
        .last_day      (day_last)
    );

    // Carry chain: weekday and day both advance on the hour wrap
    always_comb begin
        inc[F_SEC]   = tick;
        inc[F_MIN]   = carry[F_SEC];
        inc[F_HOUR]  = carry[F_MIN];
        inc[F_WDAY]  = carry[F_HOUR];
        inc[F_DAY]   = carry[F_HOUR];
        inc[F_MONTH] = carry[F_DAY];
        inc[F_YEAR]  = carry[F_MONTH];
    end

    // Field limits: fixed except day, which follows the month length
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            lim[i] = FIELD_LIMIT[i];
        end
        lim[F_DAY] = day_last;
    end

    // Load values; seconds always restart from zero
    always_comb begin
        ldv[F_SEC]   = '0;
        ldv[F_MIN]   = ld_min;
        ldv[F_HOUR]  = ld_hour;
        ldv[F_WDAY]  = ld_wday;
        ldv[F_DAY]   = ld_day;
        ldv[F_MONTH] = ld_month;
        ldv[F_YEAR]  = ld_year;
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        rtc_bcd_field #(
            .MASK     (FIELD_MASK[g]),
            .RST_VAL  (FIELD_FIRST[g]),
            .WRAP_VAL (FIELD_FIRST[g])
        ) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (inc[g]),
            .load     (load),
            .load_val (ldv[g]),
            .limit    (lim[g]),
            .value    (val[g]),
            .carry    (carry[g])
        );
    end

    // Snapshot outputs
    always_comb begin
        tm_sec   = val[F_SEC];
        tm_min   = val[F_MIN];
        tm_hour  = val[F_HOUR];
        tm_wday  = val[F_WDAY];
        tm_day   = val[F_DAY];
        tm_month = val[F_MONTH];
        tm_year  = val[F_YEAR];
    end

endmodule

// File: rtl/rtc_calendar_checker.sv
// Module: property checker for the BCD calendar counter, bound to the top.
// Observes ports only.
module rtc_calendar_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_en,
    input logic       hold,
    input logic       load,
    input logic [7:0] tm_sec,
    input logic [7:0] tm_min,
    input logic [7:0] tm_hour,
    input logic [7:0] tm_wday,
    input logic [7:0] tm_day,
    input logic [7:0] tm_month,
    input logic [7:0] tm_year
);

    // R9
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_sec[7] == 1'b0) && (tm_min[7] == 1'b0) && (tm_hour[7:6] == 2'b00) &&
        (tm_wday[7:3] == 5'b0) && (tm_day[7:6] == 2'b00) && (tm_month[7:5] == 3'b0));

    // R8
    load_zero_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tm_sec == 8'h00));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load) |=> ($stable(tm_sec) && $stable(tm_min) && $stable(tm_hour) &&
                             $stable(tm_wday) && $stable(tm_day) && $stable(tm_month) &&
                             $stable(tm_year)));

    // R2
    no_enable_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !load) |=> ($stable(tm_sec) && $stable(tm_day)));

    // R3
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_sec <= 8'h59) && (tm_sec[3:0] <= 4'd9));

    // R4
    wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_wday >= 8'h01) && (tm_wday <= 8'h07));

    // R6
    feb_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_month == 8'h02) |-> (tm_day <= 8'h29));

    // R5
    day_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_day != 8'h00) && (tm_month != 8'h00) && (tm_year[3:0] <= 4'd9));

endmodule

bind bcd_calendar_counter rtc_calendar_checker u_rtc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .hold     (hold),
    .load     (load),
    .tm_sec   (tm_sec),
    .tm_min   (tm_min),
    .tm_hour  (tm_hour),
    .tm_wday  (tm_wday),
    .tm_day   (tm_day),
    .tm_month (tm_month),
    .tm_year  (tm_year)
);

// File: tb/bcd_calendar_counter_test.sv
// Bench: behavioural calendar model compared on every falling edge,
// plus directed checks at rollovers, hold, load and masking.
module bcd_calendar_counter_test;

    localparam int TB_DIV = 4;
    localparam int TICK   = 1 << TB_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       hold = 1'b0;
    logic       load = 1'b0;
    logic [7:0] ld_min = '0, ld_hour = '0, ld_wday = 8'h01;
    logic [7:0] ld_day = 8'h01, ld_month = 8'h01, ld_year = '0;
    logic [7:0] tm_sec, tm_min, tm_hour, tm_wday, tm_day, tm_month, tm_year;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_sec, m_min, m_hour, m_wday, m_day, m_month, m_year, m_div;
    bit mdl_valid = 1'b0;

    bcd_calendar_counter #(.DIV_BITS(TB_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .hold(hold), .load(load),
        .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday), .ld_day(ld_day),
        .ld_month(ld_month), .ld_year(ld_year),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
        .tm_day(tm_day), .tm_month(tm_month), .tm_year(tm_year)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_days(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_advance();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
                    m_day++;
                    if (m_day > month_days(m_month, m_year)) begin
                        m_day = 1; m_month++;
                        if (m_month == 13) begin
                            m_month = 1;
                            m_year = (m_year + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    // Reference model, stepped on the same rising edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_wday = 1;
            m_day = 1; m_month = 1; m_year = 0; m_div = 0;
            mdl_valid = 1'b1;
        end else if (load) begin
            m_min   = from_bcd(ld_min & 8'h7F);
            m_hour  = from_bcd(ld_hour & 8'h3F);
            m_wday  = from_bcd(ld_wday & 8'h07);
            m_day   = from_bcd(ld_day & 8'h3F);
            m_month = from_bcd(ld_month & 8'h1F);
            m_year  = from_bcd(ld_year);
            m_sec = 0; m_div = 0;
        end else if (hold) begin
            m_div = 0;
        end else if (osc_en) begin
            if (m_div == TICK - 1) begin
                m_div = 0;
                m_advance();
            end else begin
                m_div++;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && mdl_valid) begin
            chk("R2 seconds",  tm_sec,   to_bcd(m_sec));
            chk("R3 minutes",  tm_min,   to_bcd(m_min));
            chk("R3 hours",    tm_hour,  to_bcd(m_hour));
            chk("R4 weekday",  tm_wday,  to_bcd(m_wday));
            chk("R5 day",      tm_day,   to_bcd(m_day));
            chk("R5 month",    tm_month, to_bcd(m_month));
            chk("R6 year",     tm_year,  to_bcd(m_year));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_load(input logic [7:0] y, mo, d, w, h, mi);
        @(negedge clk);
        ld_year = y; ld_month = mo; ld_day = d; ld_wday = w; ld_hour = h; ld_min = mi;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Load 23:59 and run one full minute of ticks
    task automatic roll(input logic [7:0] y, mo, d, w);
        do_load(y, mo, d, w, 8'h23, 8'h59);
        osc_en = 1'b1;
        repeat (60 * TICK) @(negedge clk);
        osc_en = 1'b0;
    endtask

    task automatic chk_date(input string tag, input logic [7:0] y, mo, d, w);
        chk(tag, tm_year, y);
        chk(tag, tm_month, mo);
        chk(tag, tm_day, d);
        chk(tag, tm_wday, w);
        chk(tag, {tm_hour, tm_min} == 16'h0000 ? 8'h00 : 8'hFF, 8'h00);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 sec", tm_sec, 8'h00);
        chk("R1 min", tm_min, 8'h00);
        chk("R1 hour", tm_hour, 8'h00);
        chk("R1 wday", tm_wday, 8'h01);
        chk("R1 day", tm_day, 8'h01);
        chk("R1 month", tm_month, 8'h01);
        chk("R1 year", tm_year, 8'h00);
        rst_n = 1'b1;

        // R8 then R2: full period after a load
        do_load(8'h25, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20);
        chk("R8 load min", tm_min, 8'h20);
        chk("R8 load sec", tm_sec, 8'h00);
        osc_en = 1'b1;
        repeat (TICK - 1) @(negedge clk);
        chk("R8 no early tick", tm_sec, 8'h00);
        @(negedge clk);
        chk("R2 tick on last enable", tm_sec, 8'h01);

        // R2: sparse enables
        for (int i = 0; i < 300; i++) begin
            osc_en = (i % 3) != 0;
            @(negedge clk);
        end
        osc_en = 1'b0;
        repeat (20) @(negedge clk);

        // R3 R4 R5: Jan 31 -> Feb 01, weekday 7 -> 1
        roll(8'h23, 8'h01, 8'h31, 8'h07);
        chk_date("R4 R3 jan end", 8'h23, 8'h02, 8'h01, 8'h01);
        // R6: leap February
        roll(8'h24, 8'h02, 8'h28, 8'h02);
        chk_date("R6 leap 24", 8'h24, 8'h02, 8'h29, 8'h03);
        roll(8'h00, 8'h02, 8'h28, 8'h05);
        chk_date("R6 leap 00", 8'h00, 8'h02, 8'h29, 8'h06);
        roll(8'h24, 8'h02, 8'h29, 8'h04);
        chk_date("R6 feb 29 end", 8'h24, 8'h03, 8'h01, 8'h05);
        // R5: short months
        roll(8'h23, 8'h02, 8'h28, 8'h01);
        chk_date("R5 feb 28 end", 8'h23, 8'h03, 8'h01, 8'h02);
        roll(8'h23, 8'h04, 8'h30, 8'h06);
        chk_date("R5 apr 30 end", 8'h23, 8'h05, 8'h01, 8'h07);
        roll(8'h23, 8'h07, 8'h31, 8'h01);
        chk_date("R5 jul 31 end", 8'h23, 8'h08, 8'h01, 8'h02);
        // R6: year wrap
        roll(8'h99, 8'h12, 8'h31, 8'h03);
        chk_date("R6 year wrap", 8'h00, 8'h01, 8'h01, 8'h04);

        // R7: hold freezes and clears the divider
        do_load(8'h30, 8'h09, 8'h09, 8'h02, 8'h08, 8'h45);
        osc_en = 1'b1;
        repeat (3 * TICK + 5) @(negedge clk);
        chk("R7 before hold", tm_sec, 8'h03);
        hold = 1'b1;
        repeat (100) @(negedge clk);
        chk("R7 held sec", tm_sec, 8'h03);
        chk("R7 held min", tm_min, 8'h45);
        hold = 1'b0;
        repeat (TICK - 1) @(negedge clk);
        chk("R7 divider cleared", tm_sec, 8'h03);
        @(negedge clk);
        chk("R7 first tick after hold", tm_sec, 8'h04);
        osc_en = 1'b0;

        // R9: unused bits masked on load
        do_load(8'h42, 8'hE9, 8'hC7, 8'hF5, 8'hE3, 8'hD9);
        chk("R9 min mask", tm_min, 8'h59);
        chk("R9 hour mask", tm_hour, 8'h23);
        chk("R9 wday mask", tm_wday, 8'h05);
        chk("R9 day mask", tm_day, 8'h07);
        chk("R9 month mask", tm_month, 8'h09);

        // R8: load wins over hold
        hold = 1'b1;
        osc_en = 1'b1;
        do_load(8'h11, 8'h11, 8'h11, 8'h06, 8'h11, 8'h11);
        chk("R8 load under hold", tm_hour, 8'h11);
        chk("R8 load under hold sec", tm_sec, 8'h00);
        hold = 1'b0;
        repeat (5 * TICK) @(negedge clk);
        chk("R8 run after load", tm_sec, 8'h05);
        osc_en = 1'b0;
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule